// File: doc/BRIEF.md
# Pulse-Coupled Neuron Array Updater

This block holds a small image of pulse-coupled neurons in on-chip state registers and advances the whole array by one iteration each time it is started. Every neuron keeps three fixed-point state values: a leaky feeding integrator, a leaky linking integrator and a dynamic threshold. Each neuron also keeps a binary pulse from the previous iteration. On each iteration the neuron combines its 8-bit stimulus with a weighted sum of the neighbouring pulses from the previous iteration. It modulates its feeding value by its linking value, and it fires when the result rises above its threshold. Firing raises the threshold sharply, and the threshold then leaks away.

A host sets the decay factors, the potentials, the linking strength and the eight neighbour weights, then pulses `start`. The block visits the pixels in raster order, one per clock. It presents the index of the pixel it is working on so that the host can supply that pixel's stimulus in the same cycle. The new pulse of each pixel comes out as a stream with its index, and the last pixel is marked with `done`. Repeating the start gives a temporal sequence of binary segment images.

Top module: `pcnn_array`

## Requirements
- R1: After a synchronous active-low reset, all feeding, linking and threshold values and both pulse images are zero, and `busy`, `out_valid`, `done` and `out_pulse` are low.
- R2: A `start` seen while idle makes `busy` high from the next cycle. Over the following W*H cycles `pix_idx` counts from 0 up to W*H-1 in raster order (index = row*W + col). Each pixel's result appears on `out_valid`/`out_pulse`/`out_idx` one cycle after its index was on `pix_idx`. `done` is high together with the result for index W*H-1, and `busy` is low in the cycle after.
- R3: `start` has no effect while `busy` is high. An iteration always produces exactly W*H results, and no second iteration follows unless `start` is given again while idle.
- R4: Real values are 16-bit signed two's complement with 10 fraction bits (1.0 = 1024). The stimulus enters as its 8-bit value shifted left by 2. Every product is formed at full width, 512 is added, the result is shifted right arithmetically by 10 and then clamped to [-32768, 32767]. Every sum is clamped to the same range.
- R5: The neighbour sum Q of a pixel is the clamped sum of the weights of those of its eight neighbours that pulsed in the previous iteration. Weight k sits in `weights[16k+15:16k]`, with k = 0..7 for the offsets (row,col) = (-1,-1),(-1,0),(-1,+1),(0,-1),(0,+1),(+1,-1),(+1,0),(+1,+1). Neighbours outside the image count as not pulsed. Pulses written during the current iteration never enter Q.
- R6: The new feeding value is the clamped sum of decay_f*F_old, pot_f*Q and the scaled stimulus.
- R7: The new linking value is the clamped sum of decay_l*L_old and pot_l*Q.
- R8: The activity is U = F_new * clamp(1.0 + beta*L_new). The pulse is 1 exactly when U is strictly greater than the stored threshold.
- R9: The new stored threshold is the clamped sum of decay_t*T_old and, if the pixel pulsed in this iteration, pot_t.
- R10: In the first iteration after reset, a pixel pulses if and only if its stimulus is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one iteration (honoured only when idle) |
| stim | input | 8 | Stimulus of the pixel named by `pix_idx` |
| decay_f | input | 16 | Feeding decay factor, fixed-point |
| decay_l | input | 16 | Linking decay factor, fixed-point |
| decay_t | input | 16 | Threshold decay factor, fixed-point |
| pot_f | input | 16 | Feeding potential, fixed-point |
| pot_l | input | 16 | Linking potential, fixed-point |
| pot_t | input | 16 | Threshold potential, fixed-point |
| beta | input | 16 | Linking strength, fixed-point |
| weights | input | 128 | Eight neighbour weights, 16 bits each |
| busy | output | 1 | Iteration in progress |
| pix_idx | output | 6 | Pixel whose stimulus is consumed this cycle |
| out_valid | output | 1 | Result valid |
| out_pulse | output | 1 | New pulse of pixel `out_idx` |
| out_idx | output | 6 | Index of the reported pixel |
| done | output | 1 | Marks the result of the last pixel |

## Verification
The bench checks the image borders with a weight placed on only one corner neighbour. If the design wrapped neighbours from the opposite edge, or read a neighbour outside the image as pulsed, stray pulses would appear along the first row or first column. A phase with very large weights and potentials forces every clamp. A design that wrapped instead of clamping would lose pulses, because the wrapped values turn negative. A start pulse given in the middle of an iteration exposes a design that restarts or runs twice. Random iterations compare each pulse with a model that uses only the previous image. A design that read the pulses of the current iteration would drift from that model within a few frames.

// File: rtl/pcnn_pkg.sv
// Shared fixed-point format and arithmetic for the pulse-coupled array.
// Assumes values are signed, FX_W bits wide with FX_FRAC fraction bits.
package pcnn_pkg;
    localparam int FX_W    = 16;
    localparam int FX_FRAC = 10;
    localparam int STIM_W  = 8;
    localparam int NBR     = 8;
    localparam int FX_MAX  = (1 << (FX_W - 1)) - 1;
    localparam int FX_MIN  = -(1 << (FX_W - 1));

    typedef logic signed [FX_W-1:0] fx_t;

    localparam fx_t FX_ONE = fx_t'(1 << FX_FRAC);

    // Clamp a wide signed value into the storage format.
    function automatic fx_t fx_sat(input logic signed [31:0] v);
        if (v > 32'(FX_MAX))      return fx_t'(FX_MAX);
        else if (v < 32'(FX_MIN)) return fx_t'(FX_MIN);
        else                      return fx_t'(v);
    endfunction

    // Full-width product, round half up, scale back, clamp.
    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        logic signed [31:0] p;
        p = 32'(a) * 32'(b);
        p = (p + (32'sd1 <<< (FX_FRAC - 1))) >>> FX_FRAC;
        return fx_sat(p);
    endfunction

    // Place an unsigned stimulus byte into the fixed-point format.
    function automatic fx_t fx_stim(input logic [STIM_W-1:0] s);
        logic signed [31:0] v;
        v = 32'(s);
        v = v <<< (FX_FRAC - STIM_W);
        return fx_sat(v);
    endfunction
endpackage

// File: rtl/pcnn_pulse_bank.sv
// Double-buffered pulse image. One bank is read as the previous
// iteration's image while the new pulses go into the other one.
// Assumes flip is raised together with the write of the last pixel.
module pcnn_pulse_bank #(
    parameter int N    = 64,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic            wr_bit,
    input  logic            flip,
    output logic [N-1:0]    prev_img
);
    logic [N-1:0] bank [2];
    logic         sel;

    // Read side: the bank holding the finished previous image.
    assign prev_img = bank[sel];

    // Write side and bank swap at the end of an iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank[0] <= '0;
            bank[1] <= '0;
            sel     <= 1'b0;
        end else begin
            if (wr_en) bank[~sel][wr_idx] <= wr_bit;
            if (flip)  sel <= ~sel;
        end
    end

    AST_PREV_IMG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !flip |=> $stable(prev_img)); // R5
endmodule

// File: rtl/pcnn_nbr_sum.sv
// Weighted sum of the eight neighbour pulses of one pixel.
// Assumes W and H are at least 2; neighbours outside the image are off.
module pcnn_nbr_sum
    import pcnn_pkg::*;
#(
    parameter int W  = 8,
    parameter int H  = 8,
    parameter int RW = $clog2(H),
    parameter int CW = $clog2(W)
) (
    input  logic [W*H-1:0]      prev_img,
    input  logic [RW-1:0]       row,
    input  logic [CW-1:0]       col,
    input  logic [NBR*FX_W-1:0] weights,
    output fx_t                 q
);
    // Accumulate the weight of each pulsed in-image neighbour, then clamp.
    always_comb begin
        logic signed [31:0] acc;
        acc = '0;
        for (int k = 0; k < NBR; k++) begin
            int pos, r, c;
            pos = (k < 4) ? k : k + 1;
            r   = int'(row) + pos / 3 - 1;
            c   = int'(col) + pos % 3 - 1;
            if (r >= 0 && r < H && c >= 0 && c < W) begin
                if (prev_img[r*W + c])
                    acc = acc + 32'(fx_t'(weights[k*FX_W +: FX_W]));
            end
        end
        q = fx_sat(acc);
    end
endmodule

// File: rtl/pcnn_cell_update.sv
// One neuron step: feeding, linking, activity, pulse and threshold.
// Purely combinational; assumes all inputs share the fixed-point format.
module pcnn_cell_update
    import pcnn_pkg::*;
(
    input  fx_t               f_old,
    input  fx_t               l_old,
    input  fx_t               t_old,
    input  fx_t               q,
    input  logic [STIM_W-1:0] stim,
    input  fx_t               decay_f,
    input  fx_t               decay_l,
    input  fx_t               decay_t,
    input  fx_t               pot_f,
    input  fx_t               pot_l,
    input  fx_t               pot_t,
    input  fx_t               beta,
    output fx_t               f_new,
    output fx_t               l_new,
    output fx_t               t_new,
    output logic              pulse
);
    fx_t u, gain;

    // Leaky integrators, modulation, comparison and threshold raise.
    always_comb begin
        f_new = fx_sat(32'(fx_mul(decay_f, f_old)) + 32'(fx_mul(pot_f, q))
                       + 32'(fx_stim(stim)));
        l_new = fx_sat(32'(fx_mul(decay_l, l_old)) + 32'(fx_mul(pot_l, q)));
        gain  = fx_sat(32'(FX_ONE) + 32'(fx_mul(beta, l_new)));
        u     = fx_mul(f_new, gain);
        pulse = (u > t_old);
        t_new = fx_sat(32'(fx_mul(decay_t, t_old)) + (pulse ? 32'(pot_t) : 32'sd0));
    end
endmodule

// File: rtl/pcnn_array.sv
// Iteration sequencer and state store for a W x H pulse-coupled array.
// Visits pixels in raster order, one per clock, and streams the pulses.
// Assumes the host drives stim for pix_idx in the same cycle.
module pcnn_array
    import pcnn_pkg::*;
#(
    parameter int W    = 8,
    parameter int H    = 8,
    parameter int N    = W * H,
    parameter int IDXW = $clog2(N),
    parameter int RW   = $clog2(H),
    parameter int CW   = $clog2(W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [STIM_W-1:0]   stim,
    input  logic [FX_W-1:0]     decay_f,
    input  logic [FX_W-1:0]     decay_l,
    input  logic [FX_W-1:0]     decay_t,
    input  logic [FX_W-1:0]     pot_f,
    input  logic [FX_W-1:0]     pot_l,
    input  logic [FX_W-1:0]     pot_t,
    input  logic [FX_W-1:0]     beta,
    input  logic [NBR*FX_W-1:0] weights,
    output logic                busy,
    output logic [IDXW-1:0]     pix_idx,
    output logic                out_valid,
    output logic                out_pulse,
    output logic [IDXW-1:0]     out_idx,
    output logic                done
);
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);
    localparam logic [CW-1:0]   LAST_COL = CW'(W - 1);

    fx_t f_mem [N];
    fx_t l_mem [N];
    fx_t t_mem [N];

    logic [IDXW-1:0] idx;
    logic [RW-1:0]   row;
    logic [CW-1:0]   col;
    logic [N-1:0]    prev_img;
    fx_t             q, f_new, l_new, t_new;
    logic            pulse;
    logic            last_pix;

    assign pix_idx  = idx;
    assign last_pix = busy && (idx == LAST);

    pcnn_pulse_bank #(.N(N), .IDXW(IDXW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(busy), .wr_idx(idx),
        .wr_bit(pulse), .flip(last_pix), .prev_img(prev_img)
    );

    pcnn_nbr_sum #(.W(W), .H(H), .RW(RW), .CW(CW)) u_nbr (
        .prev_img(prev_img), .row(row), .col(col), .weights(weights), .q(q)
    );

    pcnn_cell_update u_cell (
        .f_old(f_mem[idx]), .l_old(l_mem[idx]), .t_old(t_mem[idx]), .q(q),
        .stim(stim), .decay_f(decay_f), .decay_l(decay_l), .decay_t(decay_t),
        .pot_f(pot_f), .pot_l(pot_l), .pot_t(pot_t), .beta(beta),
        .f_new(f_new), .l_new(l_new), .t_new(t_new), .pulse(pulse)
    );

    // Sequencer: launch on start, walk the raster, emit one result per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            idx       <= '0;
            row       <= '0;
            col       <= '0;
            out_valid <= 1'b0;
            out_pulse <= 1'b0;
            out_idx   <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= busy;
            done      <= last_pix;
            if (busy) begin
                out_pulse <= pulse;
                out_idx   <= idx;
                if (last_pix) begin
                    busy <= 1'b0;
                    idx  <= '0;
                    row  <= '0;
                    col  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                    if (col == LAST_COL) begin
                        col <= '0;
                        row <= row + 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
            end else if (start) begin
                busy <= 1'b1;
            end
        end
    end

    // Neuron state store, written back as each pixel is processed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                f_mem[i] <= '0;
                l_mem[i] <= '0;
                t_mem[i] <= '0;
            end
        end else if (busy) begin
            f_mem[idx] <= f_new;
            l_mem[idx] <= l_new;
            t_mem[idx] <= t_new;
        end
    end

    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid && out_idx == LAST); // R2
    AST_FIRST_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_idx == '0); // R2
    AST_RESULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !done |=> out_valid && out_idx == IDXW'($past(out_idx) + 1'b1)); // R2
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !out_valid); // R2
    AST_RUN_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && pix_idx != LAST |=> busy && pix_idx == IDXW'($past(pix_idx) + 1'b1)); // R3
endmodule

// File: tb/pcnn_array_test.sv
// Self-checking bench: random parameters and stimuli with a fixed seed,
// plus directed border, clamp and ignored-start cases, against a model.
module pcnn_array_test;
    localparam int W = 8, H = 8, N = W * H, IDXW = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] stim;
    logic [15:0] decay_f, decay_l, decay_t, pot_f, pot_l, pot_t, beta;
    logic [127:0] weights;
    logic busy, out_valid, out_pulse, done;
    logic [IDXW-1:0] pix_idx, out_idx;

    int total = 0, bad = 0;
    bit finished = 0;
    int img [N];
    int wt [8];
    int mf [N], ml [N], mt [N];
    bit my [N], ey [N];

    always #10 clk = ~clk;

    always_comb stim = 8'(img[pix_idx]);
    always_comb for (int k = 0; k < 8; k++) weights[k*16 +: 16] = 16'(wt[k]);

    pcnn_array uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stim(stim),
        .decay_f(decay_f), .decay_l(decay_l), .decay_t(decay_t),
        .pot_f(pot_f), .pot_l(pot_l), .pot_t(pot_t), .beta(beta),
        .weights(weights), .busy(busy), .pix_idx(pix_idx),
        .out_valid(out_valid), .out_pulse(out_pulse), .out_idx(out_idx), .done(done)
    );

    function automatic int fsat(int v);
        return (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
    endfunction
    function automatic int fmul(int a, int b);
        int p;
        p = a * b;
        return fsat((p + 512) >>> 10);
    endfunction
    function automatic int s16(logic [15:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model of one iteration (R5..R9), reading only the previous pulse image.
    task automatic model_iter();
        for (int i = 0; i < N; i++) begin
            int r, c, q, f, l, u, g;
            r = i / W; c = i % W; q = 0;
            for (int k = 0; k < 8; k++) begin
                int pos, rr, cc;
                pos = (k < 4) ? k : k + 1;
                rr = r + pos / 3 - 1; cc = c + pos % 3 - 1;
                if (rr >= 0 && rr < H && cc >= 0 && cc < W && my[rr*W + cc])
                    q += s16(16'(wt[k]));
            end
            q = fsat(q);
            f = fsat(fmul(s16(decay_f), mf[i]) + fmul(s16(pot_f), q) + img[i] * 4);  // R6
            l = fsat(fmul(s16(decay_l), ml[i]) + fmul(s16(pot_l), q));                // R7
            g = fsat(1024 + fmul(s16(beta), l));
            u = fmul(f, g);
            ey[i] = (u > mt[i]);                                                      // R8
            mt[i] = fsat(fmul(s16(decay_t), mt[i]) + (ey[i] ? s16(pot_t) : 0));       // R9
            mf[i] = f; ml[i] = l;
        end
        for (int i = 0; i < N; i++) my[i] = ey[i];
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin mf[i] = 0; ml[i] = 0; mt[i] = 0; my[i] = 0; end
    endtask

    task automatic run_iter(string tag, bit poke);
        int seen;
        bit got_done;
        seen = 0; got_done = 0;
        model_iter();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int cyc = 0; cyc < N + 8 && !got_done; cyc++) begin
            @(negedge clk);
            start = (poke && cyc == 5);
            if (out_valid) begin
                chk(out_idx == IDXW'(seen), "R2 index order", int'(out_idx), seen);
                chk(out_pulse == ey[out_idx], tag, int'(out_pulse), int'(ey[out_idx]));
                seen++;
            end
            if (done) got_done = 1;
        end
        start = 1'b0;
        chk(got_done, "R2 done seen", int'(got_done), 1);
        chk(seen == N, "R2 result count", seen, N);
        @(negedge clk);
        chk(!busy && !out_valid, poke ? "R3 start ignored" : "R2 idle after done",
            int'(busy), 0);
        @(negedge clk);
        chk(!out_valid, "R3 no extra run", int'(out_valid), 0);
    endtask

    task automatic rand_params();
        decay_f = 16'($urandom_range(0, 1023));
        decay_l = 16'($urandom_range(0, 1023));
        decay_t = 16'($urandom_range(400, 1023));
        pot_f = 16'($urandom_range(0, 4096));
        pot_l = 16'($urandom_range(0, 4096));
        pot_t = 16'($urandom_range(8192, 24576));
        beta = 16'($urandom_range(0, 300));
        for (int k = 0; k < 8; k++) wt[k] = $urandom_range(0, 2048);
    endtask

    task automatic rand_image();
        for (int i = 0; i < N; i++)
            img[i] = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 255);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rand_params();
        rand_image();
        do_reset();
        @(negedge clk);
        // R1: idle outputs after reset.
        chk(!busy && !out_valid && !done && !out_pulse, "R1 reset outputs",
            int'({busy, out_valid, done, out_pulse}), 0);

        // R10 and R4: first iteration pulses exactly where stimulus is non-zero.
        model_iter();
        for (int i = 0; i < N; i++) chk(ey[i] == (img[i] != 0), "R10 model", int'(ey[i]), int'(img[i] != 0));
        for (int i = 0; i < N; i++) begin mf[i] = 0; ml[i] = 0; mt[i] = 0; my[i] = 0; end
        run_iter("R10 first pulse", 0);

        // R6/R7/R8/R9 random iterations; one with a start given mid-run (R3).
        for (int it = 0; it < 6; it++) run_iter("R6/R7/R8/R9 pulse", it == 2);
        for (int p = 0; p < 3; p++) begin
            rand_params(); rand_image();
            for (int it = 0; it < 4; it++) run_iter("R8 random pulse", 0);
        end

        // R4 clamping: huge weights and potentials.
        do_reset();
        for (int k = 0; k < 8; k++) wt[k] = 32767;
        pot_f = 16'd32767; pot_l = 16'd32767; pot_t = 16'd32767;
        beta = 16'd32767; decay_f = 16'd1023; decay_l = 16'd1023; decay_t = 16'd1000;
        rand_image();
        for (int it = 0; it < 5; it++) run_iter("R4 clamp pulse", 0);

        // R5 borders: only the up-left neighbour carries weight.
        do_reset();
        for (int k = 0; k < 8; k++) wt[k] = 0;
        wt[0] = 8000; pot_f = 16'd4096; pot_l = 16'd2048; pot_t = 16'd20480;
        beta = 16'd100; decay_f = 16'd0; decay_l = 16'd0; decay_t = 16'd512;
        for (int i = 0; i < N; i++) img[i] = (i % 3 == 0) ? 0 : 20;
        for (int it = 0; it < 4; it++) run_iter("R5 border pulse", 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule